// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block sits on two parallel MPEG transport-stream byte paths and decides, packet by packet, whether each packet is forwarded or discarded. The decision comes from a per-path pass/drop bitmap with one bit for every possible 13-bit packet identifier (PID), so 8192 bits per path, stored as bytes. A packet is 188 bytes long, starts with the sync byte 0x47 and carries its PID in header bytes 1 and 2; the block holds the first header bytes in a short delay line until the PID is known, then releases or suppresses the whole packet.

A host programs the bitmaps through a byte-wide window of four registers: a two-part pointer that selects a path bank and a byte within it, and a data register that reads or writes the selected bitmap byte. Because the data register reads back, software changes a single PID bit with a read-modify-write. The lowest 32 PIDs, which carry the stream's own tables, always pass. The upstream source must present the first three bytes of each packet on consecutive clock cycles; later bytes of the packet may have idle cycles between them.

Top module: `pidf_top`

## Requirements
- R1: After reset every output valid is low, both pointer registers read zero and every bitmap byte reads zero, so every packet with a good sync byte passes.
- R2: A byte sampled at clock edge n on a path appears on that path's outputs in the cycle that follows edge n+2, with its start flag and value unchanged and in input order; idle input cycles appear as idle output cycles.
- R3: The PID of a packet is bits 4:0 of its byte 1 (as PID bits 12:8) joined with its byte 2 (as PID bits 7:0); path p looks up bank p, byte address PID[12:3], bit PID[2:0]; a 1 drops every byte of the packet and a 0 forwards every byte.
- R4: A packet whose PID is below 0x20 is forwarded whatever the bitmap holds for it.
- R5: A packet whose start byte is not 0x47 is dropped in full.
- R6: Bytes that arrive after reset before the first start-of-packet flag on a path are dropped.
- R7: Host window: offset 0 holds byte-address bits 7:0; offset 1 holds byte-address bits 9:8 in bits 1:0 and the bank number in bit 2, and reads zero in bits 7:3; offset 2 reads and writes the bitmap byte the pointer selects; offset 3 reads zero and ignores writes.
- R8: A bitmap write is visible on the next read of offset 2 and applies to every packet whose byte 2 is sampled after the write edge; the two banks are independent, so a bit set for one path leaves the other path's packets with the same PID untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_wr | input | 1 | Host write strobe for the register at hst_addr |
| hst_addr | input | 2 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for the register at hst_addr |
| ts_in_valid | input | NUM_PATHS | Input byte valid, one bit per path |
| ts_in_sop | input | NUM_PATHS | Input start-of-packet flag, one bit per path |
| ts_in_data | input | 8*NUM_PATHS | Input bytes, path p in bits 8p+7:8p |
| ts_out_valid | output | NUM_PATHS | Output byte valid, one bit per path |
| ts_out_sop | output | NUM_PATHS | Output start-of-packet flag, one bit per path |
| ts_out_data | output | 8*NUM_PATHS | Output bytes, path p in bits 8p+7:8p |

## Verification
The stream side is driven with full 188-byte packets whose PIDs land on set bits, on clear neighbours in the same bitmap byte, below and just above the always-pass limit, and with a bad sync byte, so that the bit selection, the byte addressing and the two pass overrides are each separated from one another. Both paths run the same PID at the same time with different bank contents, which tells a shared bank from two independent ones, and one packet carries idle gaps mid-body to show that the decision holds across them. Stray bytes before the first start flag and back-to-back packets with opposite decisions check that each decision starts and ends exactly at packet boundaries.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
  // header bytes held before the decision is known (sync, PID high, PID low)
  localparam int HDR_BYTES = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    REG_PTR_LO = 2'd0,
    REG_PTR_HI = 2'd1,
    REG_BITS   = 2'd2,
    REG_NONE   = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic       v;
    logic       sop;
    logic [7:0] data;
  } beat_t;
endpackage

// File: rtl/pidf_rst_sync.sv
module pidf_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= 2'b00;
    else              sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/pidf_regs.sv
module pidf_regs import pidf_pkg::*; #(
  parameter int NUM_PATHS = 2,
  parameter int ADDR_W    = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hst_wr,
  input  logic [1:0]                    hst_addr,
  input  logic [7:0]                    hst_wdata,
  output logic [7:0]                    hst_rdata,
  input  logic [NUM_PATHS*ADDR_W-1:0]   lk_addr,
  output logic [NUM_PATHS*8-1:0]        lk_byte
);
  localparam int HI_W   = ADDR_W - 8;
  localparam int BANK_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1;
  localparam int IDX_W  = BANK_W + ADDR_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [7:0]        ptr_lo_q, ptr_lo_d;
  logic [HI_W-1:0]   ptr_hi_q, ptr_hi_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              ptr_en;
  logic              bits_en;
  logic [IDX_W-1:0]  sel_idx;
  logic [7:0]        sel_byte;
  logic [7:0]        bitmap_q [DEPTH];

  // pointer next state
  always_comb begin
    ptr_lo_d = ptr_lo_q;
    ptr_hi_d = ptr_hi_q;
    bank_d   = bank_q;
    ptr_en   = 1'b0;
    if (hst_wr && hst_addr == REG_PTR_LO) begin
      ptr_lo_d = hst_wdata;
      ptr_en   = 1'b1;
    end
    if (hst_wr && hst_addr == REG_PTR_HI) begin
      ptr_hi_d = hst_wdata[HI_W-1:0];
      bank_d   = hst_wdata[HI_W +: BANK_W];
      ptr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
      bank_q   <= '0;
    end else if (ptr_en) begin
      ptr_lo_q <= ptr_lo_d;
      ptr_hi_q <= ptr_hi_d;
      bank_q   <= bank_d;
    end
  end

  assign sel_idx  = {bank_q, ptr_hi_q, ptr_lo_q};
  assign bits_en  = hst_wr && (hst_addr == REG_BITS);
  assign sel_byte = bitmap_q[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bitmap_q[i] <= '0;
    end else if (bits_en) begin
      bitmap_q[sel_idx] <= hst_wdata;
    end
  end

  // read mux
  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      REG_PTR_LO: hst_rdata = ptr_lo_q;
      REG_PTR_HI: begin
        hst_rdata[HI_W-1:0]       = ptr_hi_q;
        hst_rdata[HI_W +: BANK_W] = bank_q;
      end
      REG_BITS:   hst_rdata = sel_byte;
      default:    hst_rdata = '0;
    endcase
  end

  // one lookup port per path, each bound to its own bank
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_lk
    localparam logic [BANK_W-1:0] BANK = BANK_W'(p);
    assign lk_byte[p*8 +: 8] = bitmap_q[{BANK, lk_addr[p*ADDR_W +: ADDR_W]}];
  end

  // R8
  bits_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == REG_BITS) |=> (sel_byte == $past(hst_wdata)));

  // R7
  hi_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr == REG_PTR_HI) |-> (hst_rdata[7:HI_W+BANK_W] == '0));

  // R7
  none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr == REG_NONE) |-> (hst_rdata == 8'h00));
endmodule

// File: rtl/pidf_lane.sv
module pidf_lane import pidf_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic [7:0]        lk_byte,
  output logic              out_valid,
  output logic              out_sop,
  output logic [7:0]        out_data
);
  localparam int PHI_W = ADDR_W - 5;     // PID bits above the low byte
  localparam int LAST  = HDR_BYTES - 1;

  logic [1:0]       idx_q, idx_d;        // index of next byte, 3 = past header
  logic             sync_q, sync_d;
  logic [PHI_W-1:0] hi_q, hi_d;
  logic             pass_q, pass_d;
  logic             low_pid;
  logic             drop_bit;
  beat_t            pipe_q [HDR_BYTES];
  beat_t            pipe_d [HDR_BYTES];

  assign lk_addr  = {hi_q, in_data[7:3]};
  assign drop_bit = lk_byte[in_data[2:0]];
  assign low_pid  = (hi_q == '0) && (in_data[7:5] == 3'd0);

  // header parse next state
  always_comb begin
    idx_d  = idx_q;
    sync_d = sync_q;
    hi_d   = hi_q;
    pass_d = pass_q;
    if (in_sop) begin
      idx_d  = 2'd1;
      sync_d = (in_data == SYNC_BYTE);
    end else begin
      if (idx_q == 2'd1) hi_d = in_data[PHI_W-1:0];
      if (idx_q == 2'd2) pass_d = sync_q && (low_pid || !drop_bit);
      if (idx_q != 2'd3) idx_d = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 2'd3;
      sync_q <= 1'b0;
      hi_q   <= '0;
      pass_q <= 1'b0;
    end else if (in_valid) begin
      idx_q  <= idx_d;
      sync_q <= sync_d;
      hi_q   <= hi_d;
      pass_q <= pass_d;
    end
  end

  // header delay line
  always_comb begin
    pipe_d[0] = '{v: in_valid, sop: in_sop, data: in_data};
    for (int s = 1; s < HDR_BYTES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < HDR_BYTES; s++) pipe_q[s] <= '0;
    end else begin
      for (int s = 0; s < HDR_BYTES; s++) pipe_q[s] <= pipe_d[s];
    end
  end

  assign out_valid = pipe_q[LAST].v && pass_q;
  assign out_sop   = pipe_q[LAST].sop && out_valid;
  assign out_data  = pipe_q[LAST].data;

  // R5
  bad_sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q[LAST].v && pipe_q[LAST].sop && pipe_q[LAST].data != SYNC_BYTE) |-> !out_valid);

  // R4
  low_pid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && idx_q == 2'd2 && sync_q && hi_q == '0 && in_data[7:5] == 3'd0)
      |=> pass_q);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid, 3) && $past(in_sop, 3) == out_sop
                   && $past(in_data, 3) == out_data));
endmodule

// File: rtl/pidf_top.sv
module pidf_top import pidf_pkg::*; #(
  parameter int NUM_PATHS = 2,
  parameter int PID_W     = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hst_wr,
  input  logic [1:0]             hst_addr,
  input  logic [7:0]             hst_wdata,
  output logic [7:0]             hst_rdata,
  input  logic [NUM_PATHS-1:0]   ts_in_valid,
  input  logic [NUM_PATHS-1:0]   ts_in_sop,
  input  logic [NUM_PATHS*8-1:0] ts_in_data,
  output logic [NUM_PATHS-1:0]   ts_out_valid,
  output logic [NUM_PATHS-1:0]   ts_out_sop,
  output logic [NUM_PATHS*8-1:0] ts_out_data
);
  localparam int ADDR_W = PID_W - 3;

  logic                        rst_n_i;
  logic [NUM_PATHS*ADDR_W-1:0] lk_addr_w;
  logic [NUM_PATHS*8-1:0]      lk_byte_w;

  pidf_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  pidf_regs #(.NUM_PATHS(NUM_PATHS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .lk_addr   (lk_addr_w),
    .lk_byte   (lk_byte_w)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_lane
    pidf_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .in_valid  (ts_in_valid[p]),
      .in_sop    (ts_in_sop[p]),
      .in_data   (ts_in_data[p*8 +: 8]),
      .lk_addr   (lk_addr_w[p*ADDR_W +: ADDR_W]),
      .lk_byte   (lk_byte_w[p*8 +: 8]),
      .out_valid (ts_out_valid[p]),
      .out_sop   (ts_out_sop[p]),
      .out_data  (ts_out_data[p*8 +: 8])
    );
  end
endmodule

// File: tb/pidf_top_test.sv
module pidf_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_wr;
  logic [1:0]  hst_addr;
  logic [7:0]  hst_wdata;
  logic [7:0]  hst_rdata;
  logic [1:0]  in_v, in_s;
  logic [15:0] in_d;
  logic [1:0]  out_v, out_s;
  logic [15:0] out_d;

  always #10 clk = ~clk;

  pidf_top uut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .ts_in_valid(in_v), .ts_in_sop(in_s), .ts_in_data(in_d),
    .ts_out_valid(out_v), .ts_out_sop(out_s), .ts_out_data(out_d)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  typedef struct {bit v; bit s; logic [7:0] d; int pkt;} ent_t;
  logic [7:0] m_bits [2][1024];
  int         m_pkt  [2];
  int         m_idx  [2];
  logic [4:0] m_hi   [2];
  bit         m_sync [2];
  bit         m_pass [2][64];
  ent_t       m_q    [2][$];
  logic [7:0] m_lo;
  logic [2:0] m_hreg;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 1024; a++) m_bits[b][a] = 8'h00;
      m_pkt[b] = -1; m_idx[b] = 3; m_hi[b] = '0; m_sync[b] = 0;
    end
    m_lo = '0; m_hreg = '0;
  end

  // behavioural reference, updated at each active edge
  always @(posedge clk) begin
    if (model_on) begin
      for (int l = 0; l < 2; l++) begin
        logic [7:0] byt;
        byt = in_d[l*8 +: 8];
        if (in_v[l]) begin
          if (in_s[l]) begin
            m_pkt[l]++;
            m_idx[l] = 1;
            m_sync[l] = (byt == 8'h47);
            m_pass[l][m_pkt[l]] = 0;
          end else if (m_idx[l] < 3) begin
            if (m_idx[l] == 1) m_hi[l] = byt[4:0];
            if (m_idx[l] == 2) begin
              int pid;
              pid = {m_hi[l], byt};
              m_pass[l][m_pkt[l]] = m_sync[l] &&
                ((pid < 32) || (m_bits[l][pid >> 3][pid & 7] == 1'b0));
            end
            m_idx[l]++;
          end
        end
        m_q[l].push_back('{v: in_v[l], s: in_s[l], d: byt, pkt: m_pkt[l]});
        if (m_q[l].size() > 3) void'(m_q[l].pop_front());
      end
      if (hst_wr) begin
        case (hst_addr)
          2'd0: m_lo = hst_wdata;
          2'd1: m_hreg = hst_wdata[2:0];
          2'd2: m_bits[m_hreg[2]][{m_hreg[1:0], m_lo}] = hst_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare outputs away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      for (int l = 0; l < 2; l++) begin
        bit ev;
        ev = (m_q[l].size() == 3) && m_q[l][0].v && (m_q[l][0].pkt >= 0)
             && m_pass[l][m_q[l][0].pkt];
        chk(cur_req, $sformatf("lane%0d valid", l), int'(out_v[l]), int'(ev));
        if (ev) begin
          chk(cur_req, $sformatf("lane%0d sop", l), int'(out_s[l]), int'(m_q[l][0].s));
          chk(cur_req, $sformatf("lane%0d data", l), int'(out_d[l*8 +: 8]), int'(m_q[l][0].d));
        end
      end
    end
  end

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd_chk(string req, input logic [1:0] a, input int exp);
    @(negedge clk);
    hst_addr = a;
    #2;
    chk(req, $sformatf("read off%0d", a), int'(hst_rdata), exp);
  endtask

  // read-modify-write of one PID bit in one bank (R8)
  task automatic set_pid(input int bank, input int pid, input bit val);
    logic [7:0] cur;
    logic [9:0] ba;
    ba = 10'(pid >> 3);
    hwr(2'd0, ba[7:0]);
    hwr(2'd1, {5'd0, 1'(bank), ba[9:8]});
    @(negedge clk);
    hst_addr = 2'd2;
    #2;
    cur = hst_rdata;
    chk("R8", "rmw read", int'(cur), int'(m_bits[bank][ba]));
    if (val) cur = cur | (8'h01 << (pid & 7));
    else     cur = cur & ~(8'h01 << (pid & 7));
    hwr(2'd2, cur);
    hrd_chk("R8", 2'd2, int'(cur));
  endtask

  task automatic send(input int pid0, input logic [7:0] sy0,
                      input int pid1, input logic [7:0] sy1, input bit gap);
    for (int i = 0; i < 188; i++) begin
      if (gap && i == 100) begin
        @(negedge clk);
        in_v = 2'b00; in_s = 2'b00;
        repeat (3) @(negedge clk);
      end else begin
        @(negedge clk);
      end
      in_v = 2'b11;
      in_s = (i == 0) ? 2'b11 : 2'b00;
      for (int l = 0; l < 2; l++) begin
        int pid;
        logic [7:0] b;
        pid = (l == 0) ? pid0 : pid1;
        if (i == 0)      b = (l == 0) ? sy0 : sy1;
        else if (i == 1) b = {3'b000, 5'(pid >> 8)};
        else if (i == 2) b = 8'(pid);
        else             b = 8'(i * 7 + l * 3 + pid);
        in_d[l*8 +: 8] = b;
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_v = 2'b00; in_s = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; hst_wr = 1'b0; hst_addr = 2'd0; hst_wdata = 8'h00;
    in_v = 2'b00; in_s = 2'b00; in_d = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_v), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state through the host window
    cur_req = "R1";
    hrd_chk("R1", 2'd0, 0);
    hrd_chk("R1", 2'd1, 0);
    hrd_chk("R1", 2'd2, 0);
    hwr(2'd0, 8'h80); hwr(2'd1, 8'h07);
    hrd_chk("R1", 2'd2, 0);

    // R6 stray bytes before the first start flag
    cur_req = "R6";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_v = 2'b11; in_s = 2'b00; in_d = 16'h4747;
    end
    idle(4);
    chk("R6", "no output from stray bytes", int'(out_v), 0);

    // R7 register map
    cur_req = "R7";
    hwr(2'd0, 8'hA5);
    hwr(2'd1, 8'hFF);
    hrd_chk("R7", 2'd0, 8'hA5);
    hrd_chk("R7", 2'd1, 8'h07);
    hwr(2'd3, 8'h55);
    hrd_chk("R7", 2'd3, 0);
    hrd_chk("R7", 2'd0, 8'hA5);
    hwr(2'd2, 8'h3C);
    hrd_chk("R7", 2'd2, 8'h3C);
    hwr(2'd1, 8'h03);
    hrd_chk("R7", 2'd2, 0);
    hwr(2'd1, 8'h07);
    hwr(2'd2, 8'h00);

    // R1 default: every good packet passes
    cur_req = "R1";
    send(13'h123, 8'h47, 13'h1FFF, 8'h47, 1'b0);
    idle(4);

    // R3 bit selection, R8 bank independence
    cur_req = "R3";
    set_pid(0, 13'h123, 1'b1);
    send(13'h123, 8'h47, 13'h123, 8'h47, 1'b0);
    send(13'h122, 8'h47, 13'h124, 8'h47, 1'b0);
    idle(4);
    cur_req = "R8";
    set_pid(1, 13'h1ABC, 1'b1);
    send(13'h1ABC, 8'h47, 13'h1ABC, 8'h47, 1'b0);
    set_pid(0, 13'h123, 1'b0);
    send(13'h123, 8'h47, 13'h1ABD, 8'h47, 1'b0);
    idle(4);

    // R4 low PIDs always pass, 0x20 does not
    cur_req = "R4";
    hwr(2'd0, 8'h00); hwr(2'd1, 8'h00); hwr(2'd2, 8'hFF);
    hwr(2'd0, 8'h03); hwr(2'd2, 8'hFF);
    hwr(2'd0, 8'h04); hwr(2'd2, 8'hFF);
    hwr(2'd0, 8'h03); hwr(2'd1, 8'h04); hwr(2'd2, 8'hFF);
    send(13'h005, 8'h47, 13'h01F, 8'h47, 1'b0);
    send(13'h020, 8'h47, 13'h000, 8'h47, 1'b0);
    idle(4);

    // R5 bad sync byte
    cur_req = "R5";
    send(13'h100, 8'h46, 13'h100, 8'h47, 1'b0);
    send(13'h101, 8'h47, 13'h101, 8'hB8, 1'b0);
    idle(4);

    // R2 gaps mid-packet and back-to-back opposite decisions
    cur_req = "R2";
    send(13'h0A5, 8'h47, 13'h020, 8'h47, 1'b1);
    send(13'h020, 8'h47, 13'h0A5, 8'h47, 1'b0);
    send(13'h1ABC, 8'h47, 13'h1ABC, 8'h47, 1'b1);
    idle(6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule